// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node for a range of memory blocks in a directory-based cache coherence scheme. For each block it owns, it keeps a record of which sites hold a copy, the block's directory state and the block's data. Caches send it read requests, write requests and the responses to its own recalls and invalidations on one incoming message port. It answers on one outgoing port with data grants and with recall or invalidation requests aimed at other sites.

The controller does not act atomically. When a grant depends on other sites, the block moves into one of two explicit transient states. In one it counts invalidation acknowledgements. In the other it waits for the owner to return its modified data. A request that reaches a block in a transient state is parked in a one-entry stall buffer. It is replayed when the block settles, ahead of any new input. Message delivery is assumed reliable and in order between any two sites.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is shared with an empty sharer set and data zero, `out_valid` is 0 and `in_ready` is 1.
- R2: A read request (type 1) to a block in the shared state returns a shared grant (type 11) with the stored data to the requester and adds the requester to the sharer set.
- R3: A write request (type 2) to a shared block with no sharer other than the requester returns an exclusive grant (type 12) with the stored data at once, and the requester becomes the only owner.
- R4: A write request to a shared block with other sharers sends one invalidation (type 9) to each other sharer in ascending site order. The exclusive grant is sent only after an invalidation ack (type 4) has come from every one of them. A repeated ack from a site already counted has no effect.
- R5: A read request to a block owned by another site sends a writeback request (type 8) to the owner. On the writeback reply (type 3) carrying v, the block stores v and sends a shared grant with v to the requester, and both sites remain sharers.
- R6: A write request to a block owned by another site sends a flush request (type 10) to the owner. On the flush reply (type 5) carrying v, the block stores v, sends an exclusive grant with v to the requester and records it as owner.
- R7: A request to a block in a transient state is held in a one-entry stall buffer and produces no output until the block settles. While the buffer is full, further requests are refused (`in_ready` low) while replies are still accepted.
- R8: An unsolicited flush reply from the owner stores its data and leaves the block shared with no sharers. An unsolicited invalidation ack in the shared state removes that site from the sharer set.
- R9: Every message carries a 4-bit type, a 2-bit site (sender on input, destination on output), a 4-bit block index and a 32-bit data word that is zero in outgoing requests.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outgoing message is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Incoming message accepted this cycle when valid |
| in_type | input | 4 | Incoming message type |
| in_site | input | 2 | Sending site |
| in_blk | input | 4 | Block index |
| in_data | input | 32 | Data carried by a reply |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Receiver takes the outgoing message |
| out_type | output | 4 | Outgoing message type |
| out_site | output | 2 | Destination site |
| out_blk | output | 4 | Block index |
| out_data | output | 32 | Data carried by a grant |

## Verification
The hardest situation to reach is a full stall buffer while the same block waits in a transient state. In that state a second request must be refused and the owner's reply must still get through. The stimulus first makes one site the owner of a block and then has a third site request write access, which puts the block in the wait-for-flush state. A read request to that block is then parked. A further request is presented and `in_ready` is observed low before the flush reply is delivered. The expected sequence is the exclusive grant, then the replayed read's writeback request, then its shared grant.

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl #(
  parameter int NSITE = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 32,
  localparam int SW   = $clog2(NSITE),
  localparam int BW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_type,
  input  logic [SW-1:0] in_site,
  input  logic [BW-1:0] in_blk,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    out_type,
  output logic [SW-1:0] out_site,
  output logic [BW-1:0] out_blk,
  output logic [DW-1:0] out_data
);
  localparam int CW = $clog2(NSITE + 1);

  localparam logic [3:0] T_SHREQ    = 4'd1;
  localparam logic [3:0] T_EXREQ    = 4'd2;
  localparam logic [3:0] T_WBREP    = 4'd3;
  localparam logic [3:0] T_INVREP   = 4'd4;
  localparam logic [3:0] T_FLUSHREP = 4'd5;
  localparam logic [3:0] T_WBREQ    = 4'd8;
  localparam logic [3:0] T_INVREQ   = 4'd9;
  localparam logic [3:0] T_FLUSHREQ = 4'd10;
  localparam logic [3:0] T_SHREP    = 4'd11;
  localparam logic [3:0] T_EXREP    = 4'd12;

  typedef enum logic [1:0] {D_SHR, D_OWN, D_TINV, D_TWB} dst_t;

  dst_t             st      [NBLK];
  logic [NSITE-1:0] pres    [NBLK];
  logic [DW-1:0]    mem     [NBLK];
  logic [SW-1:0]    pend    [NBLK];
  logic             pend_ex [NBLK];
  logic [CW-1:0]    cnt     [NBLK];

  logic             stall_v;
  logic [3:0]       stall_type;
  logic [SW-1:0]    stall_site;
  logic [BW-1:0]    stall_blk;

  logic             inv_busy;
  logic [NSITE-1:0] inv_mask;
  logic [BW-1:0]    inv_blk;

  function automatic logic [SW-1:0] first_site(input logic [NSITE-1:0] m);
    logic [SW-1:0] r;
    r = '0;
    for (int i = NSITE - 1; i >= 0; i--)
      if (m[i]) r = SW'(i);
    return r;
  endfunction

  function automatic logic settling(input dst_t s);
    return (s == D_TINV) || (s == D_TWB);
  endfunction

  logic slot_free, stall_go, in_is_req, in_fire, out_fire, proc;
  assign slot_free = !out_valid || out_ready;
  assign stall_go  = stall_v && !inv_busy && slot_free && !settling(st[stall_blk]);
  assign in_is_req = (in_type == T_SHREQ) || (in_type == T_EXREQ);
  assign in_ready  = !inv_busy && slot_free && !stall_go && !(stall_v && in_is_req);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign proc      = stall_go || in_fire;

  logic [3:0]       m_type;
  logic [SW-1:0]    m_site;
  logic [BW-1:0]    m_blk;
  logic [DW-1:0]    m_data;
  dst_t             m_st;
  logic [NSITE-1:0] m_pres, m_bit, others, pend_bit, inv_left;
  logic [SW-1:0]    owner, inv_tgt;

  assign m_type   = stall_go ? stall_type : in_type;
  assign m_site   = stall_go ? stall_site : in_site;
  assign m_blk    = stall_go ? stall_blk  : in_blk;
  assign m_data   = stall_go ? '0 : in_data;
  assign m_st     = st[m_blk];
  assign m_pres   = pres[m_blk];
  assign m_bit    = NSITE'(1) << m_site;
  assign others   = m_pres & ~m_bit;
  assign pend_bit = NSITE'(1) << pend[m_blk];
  assign owner    = first_site(m_pres);
  assign inv_tgt  = first_site(inv_mask);
  assign inv_left = inv_mask & ~(NSITE'(1) << inv_tgt);

  logic          e_v;
  logic [3:0]    e_type;
  logic [SW-1:0] e_site;
  logic [DW-1:0] e_data;

  always_comb begin
    e_v = 1'b0; e_type = '0; e_site = '0; e_data = '0;
    if (inv_busy) begin
      if (slot_free) begin
        e_v = 1'b1; e_type = T_INVREQ; e_site = inv_tgt;
      end
    end else if (proc) begin
      case (m_type)
        T_SHREQ: if (!settling(m_st)) begin
          e_v = 1'b1;
          if (m_st == D_SHR) begin e_type = T_SHREP; e_site = m_site; e_data = mem[m_blk]; end
          else begin e_type = T_WBREQ; e_site = owner; end
        end
        T_EXREQ: if (!settling(m_st)) begin
          if (m_st == D_OWN) begin
            e_v = 1'b1; e_type = T_FLUSHREQ; e_site = owner;
          end else if (others == '0) begin
            e_v = 1'b1; e_type = T_EXREP; e_site = m_site; e_data = mem[m_blk];
          end
        end
        T_WBREP, T_FLUSHREP: if (m_st == D_TWB && m_pres[m_site]) begin
          e_v = 1'b1; e_site = pend[m_blk]; e_data = m_data;
          e_type = pend_ex[m_blk] ? T_EXREP : T_SHREP;
        end
        T_INVREP: if (m_st == D_TINV && m_pres[m_site] && cnt[m_blk] == CW'(1)) begin
          e_v = 1'b1; e_type = T_EXREP; e_site = pend[m_blk]; e_data = mem[m_blk];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_site  <= '0;
      out_blk   <= '0;
      out_data  <= '0;
    end else if (e_v) begin
      out_valid <= 1'b1;
      out_type  <= e_type;
      out_site  <= e_site;
      out_blk   <= inv_busy ? inv_blk : m_blk;
      out_data  <= e_data;
    end else if (out_fire) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st[i]      <= D_SHR;
        pres[i]    <= '0;
        mem[i]     <= '0;
        pend[i]    <= '0;
        pend_ex[i] <= 1'b0;
        cnt[i]     <= '0;
      end
      stall_v    <= 1'b0;
      stall_type <= '0;
      stall_site <= '0;
      stall_blk  <= '0;
      inv_busy   <= 1'b0;
      inv_mask   <= '0;
      inv_blk    <= '0;
    end else if (inv_busy) begin
      if (slot_free) begin
        inv_mask <= inv_left;
        if (inv_left == '0) inv_busy <= 1'b0;
      end
    end else if (proc) begin
      if (stall_go) stall_v <= 1'b0;
      case (m_type)
        T_SHREQ, T_EXREQ: begin
          if (settling(m_st)) begin
            stall_v    <= 1'b1;
            stall_type <= m_type;
            stall_site <= m_site;
            stall_blk  <= m_blk;
          end else if (m_type == T_SHREQ) begin
            if (m_st == D_SHR) pres[m_blk] <= m_pres | m_bit;
            else begin
              st[m_blk] <= D_TWB; pend[m_blk] <= m_site; pend_ex[m_blk] <= 1'b0;
            end
          end else if (m_st == D_OWN) begin
            st[m_blk] <= D_TWB; pend[m_blk] <= m_site; pend_ex[m_blk] <= 1'b1;
          end else if (others == '0) begin
            st[m_blk] <= D_OWN; pres[m_blk] <= m_bit;
          end else begin
            st[m_blk]   <= D_TINV;
            pres[m_blk] <= others;
            cnt[m_blk]  <= CW'($countones(others));
            pend[m_blk] <= m_site;
            inv_busy    <= 1'b1;
            inv_mask    <= others;
            inv_blk     <= m_blk;
          end
        end
        T_WBREP, T_FLUSHREP: begin
          if (m_st == D_TWB && m_pres[m_site]) begin
            mem[m_blk] <= m_data;
            if (pend_ex[m_blk]) begin
              st[m_blk] <= D_OWN; pres[m_blk] <= pend_bit;
            end else begin
              st[m_blk]   <= D_SHR;
              pres[m_blk] <= pend_bit | ((m_type == T_WBREP) ? m_bit : '0);
            end
          end else if (m_st == D_OWN && m_pres[m_site] && m_type == T_FLUSHREP) begin
            mem[m_blk]  <= m_data;
            st[m_blk]   <= D_SHR;
            pres[m_blk] <= '0;
          end
        end
        T_INVREP: begin
          if (m_st == D_TINV && m_pres[m_site]) begin
            cnt[m_blk] <= cnt[m_blk] - CW'(1);
            if (cnt[m_blk] == CW'(1)) begin
              st[m_blk] <= D_OWN; pres[m_blk] <= pend_bit;
            end else pres[m_blk] <= others;
          end else if (m_st == D_SHR) begin
            pres[m_blk] <= others;
          end
        end
        default: ;
      endcase
    end
  end

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_site)
                                 && $stable(out_blk) && $stable(out_data));

  assert_shrep_sharer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_type == T_SHREP |-> st[out_blk] == D_SHR && pres[out_blk][out_site]);

  assert_exrep_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_type == T_EXREP |-> st[out_blk] == D_OWN
                                        && pres[out_blk] == (NSITE'(1) << out_site));

  assert_inv_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_type == T_INVREQ |-> st[out_blk] == D_TINV && pres[out_blk][out_site]);

  assert_ack_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_type == T_INVREP && st[in_blk] == D_TINV && pres[in_blk][in_site]
      |-> cnt[in_blk] != '0);

  assert_stall_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_v && settling(st[stall_blk]) |=> stall_v);
endmodule

// File: tb/tb_home_dir_ctrl.sv
module tb_home_dir_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [3:0]  in_type, out_type, in_blk, out_blk;
  logic [1:0]  in_site, out_site;
  logic [31:0] in_data, out_data;

  home_dir_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_site(in_site),
    .in_blk(in_blk), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_site(out_site),
    .out_blk(out_blk), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  logic [41:0] exp_q[$];
  string tag_q[$];
  logic ready_mode = 1'b0;
  int rcnt = 0;
  bit done = 0;

  task automatic expect_msg(input logic [3:0] t, input logic [1:0] s, input logic [3:0] b,
                            input logic [31:0] d, input string tag);
    exp_q.push_back({t, s, b, d});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [3:0] t, input logic [1:0] s, input logic [3:0] b,
                      input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_type = t; in_site = s; in_blk = b; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    rcnt++;
    out_ready = !ready_mode || (rcnt % 4 == 0);
  end

  initial begin : monitor
    logic hv;
    logic [41:0] hmsg, cur;
    hv = 1'b0; hmsg = '0;
    forever begin
      @(negedge clk); #5;
      cur = {out_type, out_site, out_blk, out_data};
      if (rst_n) begin
        if (hv) check(out_valid && cur == hmsg, "R10 held message", cur, hmsg);
        hv = out_valid && !out_ready;
        hmsg = cur;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(1'b0, "R4/R7/R8 unexpected output", cur, '0);
          else begin
            logic [41:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(cur == e, tg, cur, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-all actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_type = '0; in_site = '0; in_blk = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", {41'b0, out_valid}, '0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {41'b0, in_ready}, 42'd1);

    // R1 R2 R9: reads of a fresh block
    expect_msg(4'd11, 2'd1, 4'd3, 32'd0, "R2 shared grant site1");
    send(4'd1, 2'd1, 4'd3, 32'd0);
    expect_msg(4'd11, 2'd2, 4'd3, 32'd0, "R2 shared grant site2");
    send(4'd1, 2'd2, 4'd3, 32'd0);

    // R4: invalidate two sharers, duplicate ack ignored
    expect_msg(4'd9, 2'd1, 4'd3, 32'd0, "R4 inv site1");
    expect_msg(4'd9, 2'd2, 4'd3, 32'd0, "R4 inv site2");
    send(4'd2, 2'd0, 4'd3, 32'd0);
    send(4'd4, 2'd1, 4'd3, 32'd0);
    send(4'd4, 2'd1, 4'd3, 32'd0);
    repeat (6) @(negedge clk);
    expect_msg(4'd12, 2'd0, 4'd3, 32'd0, "R4 exclusive grant after acks");
    send(4'd4, 2'd2, 4'd3, 32'd0);

    // R8: unsolicited flush, then read sees stored data
    send(4'd5, 2'd0, 4'd3, 32'hA5A5_0001);
    repeat (4) @(negedge clk);
    expect_msg(4'd11, 2'd3, 4'd3, 32'hA5A5_0001, "R8 flush data kept");
    send(4'd1, 2'd3, 4'd3, 32'd0);

    // R3 and R5
    expect_msg(4'd12, 2'd2, 4'd5, 32'd0, "R3 immediate exclusive");
    send(4'd2, 2'd2, 4'd5, 32'd0);
    expect_msg(4'd8, 2'd2, 4'd5, 32'd0, "R5 writeback request to owner");
    send(4'd1, 2'd1, 4'd5, 32'd0);
    expect_msg(4'd11, 2'd1, 4'd5, 32'h0000_1234, "R5 shared grant with owner data");
    send(4'd3, 2'd2, 4'd5, 32'h0000_1234);
    expect_msg(4'd9, 2'd2, 4'd5, 32'd0, "R5 old owner still sharer");
    send(4'd2, 2'd1, 4'd5, 32'd0);
    expect_msg(4'd12, 2'd1, 4'd5, 32'h0000_1234, "R4 single sharer ack");
    send(4'd4, 2'd2, 4'd5, 32'd0);

    // R6 and R7: flush path with a parked request
    expect_msg(4'd10, 2'd1, 4'd5, 32'd0, "R6 flush request to owner");
    send(4'd2, 2'd3, 4'd5, 32'd0);
    send(4'd1, 2'd0, 4'd5, 32'd0);
    @(negedge clk);
    in_valid = 1'b1; in_type = 4'd2; in_site = 2'd2; in_blk = 4'd7; in_data = '0;
    #1;
    check(in_ready == 1'b0, "R7 request refused while stall full", {41'b0, in_ready}, '0);
    in_valid = 1'b0;
    expect_msg(4'd12, 2'd3, 4'd5, 32'h0000_BEEF, "R6 exclusive grant with flushed data");
    expect_msg(4'd8, 2'd3, 4'd5, 32'd0, "R7 replayed read recalls new owner");
    send(4'd5, 2'd1, 4'd5, 32'h0000_BEEF);
    expect_msg(4'd11, 2'd0, 4'd5, 32'h0000_CAFE, "R7 replayed read granted");
    send(4'd3, 2'd3, 4'd5, 32'h0000_CAFE);

    // R10: output backpressure
    ready_mode = 1'b1;
    expect_msg(4'd11, 2'd0, 4'd9, 32'd0, "R10 grant under backpressure a");
    send(4'd1, 2'd0, 4'd9, 32'd0);
    expect_msg(4'd11, 2'd1, 4'd9, 32'd0, "R10 grant under backpressure b");
    send(4'd1, 2'd1, 4'd9, 32'd0);
    expect_msg(4'd12, 2'd2, 4'd10, 32'd0, "R10 exclusive under backpressure");
    send(4'd2, 2'd2, 4'd10, 32'd0);
    repeat (8) @(negedge clk);
    ready_mode = 1'b0;

    // R8: unsolicited ack removes a sharer
    send(4'd4, 2'd0, 4'd9, 32'd0);
    repeat (3) @(negedge clk);
    expect_msg(4'd12, 2'd1, 4'd9, 32'd0, "R8 sharer removed, no invalidation");
    send(4'd2, 2'd1, 4'd9, 32'd0);

    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    while (exp_q.size() != 0) begin
      logic [41:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(1'b0, {tg, " missing"}, '0, e);
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule